// File: doc/BRIEF.md
# Card Clock Divider with Odd Ratio

This block derives the clock for a memory-card bus from a faster bus clock. It counts bus cycles against a programmable ratio and drives a registered card clock. Alongside it, a one-cycle strobe marks the first bus cycle of every card clock high phase, so logic on the bus clock can act on card clock edges without sampling the divided clock itself.

Two divider layouts are selectable at run time. The legacy layout gives only even ratios, from the divider field alone. The extended layout appends a single odd bit below the divider field, which makes odd ratios possible as well. Software picks the divider value.

A new setting is taken up only when the current output period ends, so a running card clock never shows a shortened phase. Dropping the enable parks the output low at once. Raising it starts a fresh period on the next cycle.

Top module: `cardclk_div`

## Requirements
- R1: With `ext_mode`=1 (extended layout), the card clock period is 2*D+O+2 bus cycles, where D is `div_val` (8 bits) and O is `odd_bit`.
- R2: With `ext_mode`=0 (legacy layout), the period is 2*(D+1) bus cycles and `odd_bit` has no effect on the output.
- R3: The ratio range reaches 513 in the extended layout (D=255, O=1), 512 in the legacy layout (D=255), and 2 at its fastest (D=0, O=0).
- R4: In each period of N cycles, `card_clk` is high for floor(N/2) cycles and then low for the rest. For an odd N the high phase is one cycle shorter than the low phase.
- R5: `rise_pulse` is high for exactly the first cycle in which `card_clk` is high, and in no other cycle.
- R6: A change to `div_val`, `odd_bit` or `ext_mode` during a period leaves that period at its old length. The new ratio applies from the next period.
- R7: When `enable` is low at a clock edge, `card_clk` and `rise_pulse` are both low after that edge. When `enable` returns high, the cycle after the edge starts a period, with `card_clk` high and `rise_pulse` high.
- R8: While `rst_n` is low, `card_clk` and `rise_pulse` are low and the cycle count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the divider when high; parks the output low when low |
| ext_mode | input | 1 | 1 selects the extended (odd-capable) layout, 0 the legacy even layout |
| div_val | input | DIV_W | Divider field D |
| odd_bit | input | 1 | Odd extension bit O; used only in the extended layout |
| card_clk | output | 1 | Divided card clock |
| rise_pulse | output | 1 | One-cycle strobe in the first high cycle of each card clock period |

## Verification
The bench builds the block with its defaults: an 8-bit divider field and the extended layout generated in. With those values the slowest ratios (512 legacy, 513 extended) fit into about a thousand bus cycles, so the saturation corners are measured directly, next to the fastest ratios of 2 and 3. The legacy-only variant selected by EXT_EN=0 is not elaborated by the bench. Its behaviour equals the ext_mode=0 path, which the bench does exercise.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
  typedef enum logic {
    LAYOUT_EVEN = 1'b0,
    LAYOUT_ODD  = 1'b1
  } layout_e;

  localparam int RATIO_MIN = 2;
endpackage

// File: rtl/cardclk_ratio.sv
module cardclk_ratio #(
  parameter int DIV_W  = 8,
  parameter bit EXT_EN = 1'b1,
  localparam int RAT_W = DIV_W + 2
) (
  input  logic             ext_mode,
  input  logic [DIV_W-1:0] div_val,
  input  logic             odd_bit,
  output logic [RAT_W-1:0] ratio
);
  import cardclk_pkg::*;

  logic [RAT_W-1:0] even_ratio;

  // Legacy: 2*(D+1)
  assign even_ratio = {1'b0, div_val, 1'b0} + RAT_W'(RATIO_MIN);

  generate
    if (EXT_EN) begin : g_ext
      logic [RAT_W-1:0] odd_ratio;
      layout_e          layout;
      // Extended: 2*D + O + 2; {D,O} is at most 2^(DIV_W+1)-1
      assign odd_ratio = {1'b0, div_val, odd_bit} + RAT_W'(RATIO_MIN);
      assign layout    = layout_e'(ext_mode);
      always_comb begin
        ratio = (layout == LAYOUT_ODD) ? odd_ratio : even_ratio;
      end
    end else begin : g_even
      logic unused_sel;
      assign unused_sel = ext_mode ^ odd_bit;
      assign ratio = even_ratio;
    end
  endgenerate
endmodule

// File: rtl/cardclk_phase.sv
module cardclk_phase #(
  parameter int RAT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [RAT_W-1:0] ratio_in,
  output logic             card_clk,
  output logic             rise_pulse
);
  import cardclk_pkg::*;

  logic [RAT_W-1:0] cnt_q;
  logic [RAT_W-1:0] ratio_q;
  logic [RAT_W-1:0] cnt_inc;
  logic [RAT_W-1:0] half_len;
  logic             run_q;
  logic             clk_q;
  logic             pls_q;
  logic             wrap;

  assign cnt_inc  = cnt_q + RAT_W'(1);
  assign half_len = ratio_q >> 1;
  assign wrap     = (cnt_inc == ratio_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= RAT_W'(RATIO_MIN);
      run_q   <= 1'b0;
      clk_q   <= 1'b0;
      pls_q   <= 1'b0;
    end else if (!enable) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      clk_q <= 1'b0;
      pls_q <= 1'b0;
    end else if (!run_q || wrap) begin
      // period boundary: the only point where a new ratio is taken
      cnt_q   <= '0;
      ratio_q <= ratio_in;
      run_q   <= 1'b1;
      clk_q   <= 1'b1;
      pls_q   <= 1'b1;
    end else begin
      cnt_q <= cnt_inc;
      clk_q <= (cnt_inc < half_len);
      pls_q <= 1'b0;
    end
  end

  assign card_clk   = clk_q;
  assign rise_pulse = pls_q;
endmodule

// File: rtl/cardclk_div.sv
module cardclk_div #(
  parameter int DIV_W  = 8,
  parameter bit EXT_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             ext_mode,
  input  logic [DIV_W-1:0] div_val,
  input  logic             odd_bit,
  output logic             card_clk,
  output logic             rise_pulse
);
  localparam int RAT_W = DIV_W + 2;

  logic [RAT_W-1:0] ratio;

  cardclk_ratio #(
    .DIV_W (DIV_W),
    .EXT_EN(EXT_EN)
  ) u_ratio (
    .ext_mode(ext_mode),
    .div_val (div_val),
    .odd_bit (odd_bit),
    .ratio   (ratio)
  );

  cardclk_phase #(
    .RAT_W(RAT_W)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .ratio_in  (ratio),
    .card_clk  (card_clk),
    .rise_pulse(rise_pulse)
  );
endmodule

// File: rtl/cardclk_chk.sv
module cardclk_chk #(
  parameter int CNT_W = 10
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic card_clk,
  input logic rise_pulse
);
  logic [CNT_W-1:0] h_len;
  logic [CNT_W-1:0] l_len;
  logic             full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_len  <= '0;
      l_len  <= '0;
      full_q <= 1'b0;
    end else if (!enable) begin
      h_len  <= '0;
      l_len  <= '0;
      full_q <= 1'b0;
    end else if (rise_pulse) begin
      h_len  <= CNT_W'(1);
      l_len  <= '0;
      full_q <= 1'b1;
    end else if (card_clk) begin
      h_len <= h_len + CNT_W'(1);
    end else begin
      l_len <= l_len + CNT_W'(1);
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_LOW: assert (!card_clk && !rise_pulse); // R8
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!card_clk && !rise_pulse)); // R7

  AST_PULSE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |-> (card_clk && !$past(card_clk))); // R5

  AST_RISE_HAS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_clk) |-> rise_pulse); // R5

  AST_DUTY_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_pulse && full_q) |-> ((l_len == h_len) || (l_len == h_len + CNT_W'(1)))); // R4
endmodule

bind cardclk_div cardclk_chk #(.CNT_W(DIV_W + 2)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .card_clk  (card_clk),
  .rise_pulse(rise_pulse)
);

// File: tb/sim_cardclk_div.sv
`timescale 1ns/1ps
module sim_cardclk_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       ext_mode = 1'b1;
  logic [7:0] div_val = 8'd0;
  logic       odd_bit = 1'b0;
  logic       card_clk;
  logic       rise_pulse;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cardclk_div u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ext_mode(ext_mode),
    .div_val(div_val), .odd_bit(odd_bit),
    .card_clk(card_clk), .rise_pulse(rise_pulse)
  );

  function automatic int exp_ratio(int d, int o, int m);
    if (m != 0) return 2 * d + o + 2;
    return 2 * (d + 1);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse(output bit ok);
    ok = 0;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (rise_pulse) begin ok = 1; break; end
    end
  endtask

  task automatic measure(output int n, output int h);
    bit ok;
    n = 0; h = 0;
    wait_pulse(ok);
    if (!ok) return;
    n = 1; h = 1;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (rise_pulse) break;
      n++;
      if (card_clk) h++;
    end
  endtask

  task automatic check_ratio(int d, int o, int m, string tag);
    int n, h, e;
    @(negedge clk);
    div_val = d[7:0]; odd_bit = o[0]; ext_mode = m[0];
    e = exp_ratio(d, o, m);
    measure(n, h);
    chk(n == e, {tag, " period"}, n, e);
    chk(h == e / 2, {"R4 high phase (", tag, ")"}, h, e / 2);
  endtask

  initial begin
    int n, h, sd;
    bit ok;
    sd = $urandom(32'd2024);
    // R8: reset state
    repeat (3) @(negedge clk);
    chk(card_clk == 0, "R8 card_clk in reset", card_clk, 0);
    chk(rise_pulse == 0, "R8 rise_pulse in reset", rise_pulse, 0);
    rst_n = 1'b1;
    enable = 1'b1;

    // R1 / R3 directed
    check_ratio(0, 0, 1, "R3 min ratio 2");
    check_ratio(0, 1, 1, "R1 ratio 3");
    check_ratio(4, 1, 1, "R1 ratio 11");
    check_ratio(7, 0, 1, "R1 ratio 16");
    check_ratio(255, 1, 1, "R3 ext max 513");
    // R2 legacy, odd ignored
    check_ratio(5, 0, 0, "R2 legacy ratio 12");
    check_ratio(5, 1, 0, "R2 legacy odd ignored");
    check_ratio(255, 1, 0, "R3 legacy max 512");
    check_ratio(0, 1, 0, "R2 legacy min 2");

    // R6: change mid-period
    check_ratio(4, 0, 1, "R6 setup ratio 10");
    n = 1;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (rise_pulse) break;
      n++;
      if (n == 3) begin div_val = 8'd1; odd_bit = 1'b0; end
    end
    chk(n == 10, "R6 old period kept", n, 10);
    measure(n, h);
    chk(n == 4, "R6 new period applied", n, 4);

    // R7: enable low
    @(negedge clk);
    enable = 1'b0;
    ok = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (card_clk || rise_pulse) ok = 0;
    end
    chk(ok, "R7 quiet while disabled", ok, 1);
    enable = 1'b1;
    @(negedge clk);
    chk(rise_pulse == 1, "R7 pulse after enable", rise_pulse, 1);
    chk(card_clk == 1, "R7 clock high after enable", card_clk, 1);
    // R5: pulse lasts one cycle
    @(negedge clk);
    chk(rise_pulse == 0, "R5 pulse one cycle", rise_pulse, 0);

    // random mix
    for (int k = 0; k < 25; k++) begin
      int d, o, m;
      d = (($urandom % 4) == 0) ? int'($urandom % 256) : int'($urandom % 24);
      o = int'($urandom % 2);
      m = int'($urandom % 2);
      check_ratio(d, o, m, m ? "R1 random" : "R2 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule